// File: doc/BRIEF.md
# Register Readiness Scoreboard with Wakeup Slots

This block tracks, for every physical register, whether its value has been produced yet. It also keeps a small table of waiting instruction slots, each with a ready flag for each of its source operands. When a producer is dispatched, its destination register drops to not-ready. When a producer completes, the register becomes ready again, and every waiting slot watching that register sees the matching source turn ready in the next cycle. A slot is eligible for issue once it is occupied and all of its sources are ready. Picking which eligible slot issues is left to the surrounding logic.

When a consumer is written into a slot, each source is resolved in one of three ways. It is already known ready from rename. Or it is looked up in the scoreboard, including a completion arriving in that same cycle, so a result produced while the consumer was in flight is never lost. Otherwise the slot waits on that register. Tags at or above the physical register count name special registers that are not tracked: they never change the scoreboard, and a source carrying one counts as ready at once. A flush mask empties slots, which removes their pending waits. The issuing side uses the same mask to release slots.

Top module: `regready_scoreboard`

## Requirements
- R1: After reset every tracked register reads ready on `reg_ready` and every slot is empty (`slot_valid`, `slot_src_ready` and `slot_eligible` all zero).
- R2: A dispatch with `disp_dst_en` set and a tracked destination tag clears that register's bit on `reg_ready` in the following cycle.
- R3: A completion with a tracked `done_tag` sets that register's bit in the following cycle.
- R4: When a dispatch clears and a completion sets the same register in one cycle, the register reads not ready afterwards.
- R5: Tags of value NUM_PREGS (64) or more are untracked: a dispatch or completion naming one leaves `reg_ready` unchanged, and a source naming one is ready as soon as it is inserted.
- R6: A source inserted with its `disp_src_pre` bit set is ready in the next cycle, whatever the scoreboard holds.
- R7: An inserted source whose register reads ready, or whose register completes in the insert cycle, is ready in the next cycle. The lookup uses the scoreboard as it stood before that cycle's own destination clear.
- R8: Any other inserted source waits. A later completion of its tag sets it ready in the following cycle, in every occupied slot that waits on that tag.
- R9: `slot_eligible[e]` is high exactly when slot e is occupied and all of its sources are ready. Source s of slot e is bit e*NUM_SRC+s of `slot_src_ready`, and source s of the dispatch is bits s*TAG_W and up of `disp_src_tag`.
- R10: A slot whose `flush_mask` bit is set becomes empty, with its source flags cleared, and later completions do not revive it. An insert to the same slot in the same cycle takes priority over the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Insert a consumer into slot `disp_slot` |
| disp_slot | input | SLOT_W (3) | Target slot of the insert |
| disp_dst_en | input | 1 | The inserted instruction writes a destination |
| disp_dst_tag | input | TAG_W (7) | Destination register tag |
| disp_src_tag | input | NUM_SRC*TAG_W (14) | Source register tags, packed |
| disp_src_pre | input | NUM_SRC (2) | Sources already known ready from rename |
| done_valid | input | 1 | A producer completes this cycle |
| done_tag | input | TAG_W (7) | Destination tag of the completing producer |
| flush_mask | input | NUM_SLOTS (8) | Slots to empty |
| reg_ready | output | NUM_PREGS (64) | Ready bit of every tracked register |
| slot_valid | output | NUM_SLOTS (8) | Slot occupied |
| slot_src_ready | output | NUM_SLOTS*NUM_SRC (16) | Per-slot, per-source ready flags |
| slot_eligible | output | NUM_SLOTS (8) | Slot occupied with all sources ready |

## Verification
The bench builds the block with the default 64 registers, a 7-bit tag, 8 slots and 2 sources. The 7-bit tag leaves tags 64 to 127 for the untracked range, so both branches of the tag filter are exercised. With eight slots, one completion can be seen waking several waiting slots at once, alongside flushes and re-inserts into occupied slots. Directed sequences cover the same-cycle cases: a completion that bypasses into an insert, dispatch against completion on one register, and an insert on top of a flush. A long run with random inputs, biased toward a few low tags, then compares every output against the reference model on each cycle.

// File: rtl/regready_pkg.sv
package regready_pkg;

   typedef enum logic [1:0] {
      SLOT_HOLD = 2'd0,
      SLOT_DROP = 2'd1,
      SLOT_LOAD = 2'd2
   } slot_op_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rr_tag_filter.sv
module rr_tag_filter #(
   parameter int unsigned NUM_PREGS = 64,
   parameter int unsigned TAG_W     = 7,
   localparam int unsigned IDX_W    = regready_pkg::idx_bits(NUM_PREGS)
) (
   input  logic [TAG_W-1:0] tag,
   output logic             tracked,
   output logic [IDX_W-1:0] idx
);

   localparam bit FULL_RANGE = ((64'd1 << TAG_W) == 64'(NUM_PREGS));
   localparam bit IS_POW2    = ((NUM_PREGS & (NUM_PREGS - 1)) == 0);

   if (NUM_PREGS < 2) begin : g_bad_count
      $error("rr_tag_filter: NUM_PREGS must be at least 2");
   end
   if ((64'd1 << TAG_W) < 64'(NUM_PREGS)) begin : g_bad_width
      $error("rr_tag_filter: TAG_W too narrow for NUM_PREGS");
   end

   if (FULL_RANGE) begin : g_full
      assign tracked = 1'b1;
   end else if (IS_POW2) begin : g_pow2
      assign tracked = ~|tag[TAG_W-1:IDX_W];
   end else begin : g_cmp
      localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_PREGS);
      assign tracked = ({1'b0, tag} < LIMIT);
   end

   assign idx = tag[IDX_W-1:0];

endmodule

// File: rtl/rr_ready_file.sv
module rr_ready_file #(
   parameter int unsigned NUM_PREGS = 64,
   parameter int unsigned TAG_W     = 7,
   parameter int unsigned NUM_SRC   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_v,
   input  logic [TAG_W-1:0]         set_tag,
   input  logic                     clr_v,
   input  logic [TAG_W-1:0]         clr_tag,
   input  logic [NUM_SRC*TAG_W-1:0] look_tag,
   output logic [NUM_SRC-1:0]       look_rdy,
   output logic [NUM_PREGS-1:0]     rdy_vec
);

   localparam int unsigned IDX_W = regready_pkg::idx_bits(NUM_PREGS);

   logic [NUM_PREGS-1:0] rdy_q;
   logic [NUM_PREGS-1:0] rdy_d;
   logic                 set_trk;
   logic                 clr_trk;
   logic [IDX_W-1:0]     set_idx;
   logic [IDX_W-1:0]     clr_idx;

   rr_tag_filter #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_set_flt (
      .tag(set_tag), .tracked(set_trk), .idx(set_idx));

   rr_tag_filter #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_clr_flt (
      .tag(clr_tag), .tracked(clr_trk), .idx(clr_idx));

   // Dispatch clear is applied after the completion set, so it wins.
   always_comb begin
      rdy_d = rdy_q;
      if (set_v && set_trk) rdy_d[set_idx] = 1'b1;
      if (clr_v && clr_trk) rdy_d[clr_idx] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q <= '1;
      else        rdy_q <= rdy_d;
   end

   assign rdy_vec = rdy_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_look
      logic [TAG_W-1:0] l_tag;
      logic             l_trk;
      logic [IDX_W-1:0] l_idx;

      assign l_tag = look_tag[s*TAG_W +: TAG_W];

      rr_tag_filter #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_look_flt (
         .tag(l_tag), .tracked(l_trk), .idx(l_idx));

      // Untracked, already produced, or produced in this very cycle.
      assign look_rdy[s] = !l_trk || rdy_q[l_idx] || (set_v && (set_tag == l_tag));
   end

   a_r2_dispatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v && clr_trk) |=> !rdy_q[$past(clr_idx)]);

   a_r3_complete_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v && set_trk && !(clr_v && clr_trk && (clr_tag == set_tag)))
      |=> rdy_q[$past(set_idx)]);

   a_r5_untracked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!(set_v && set_trk) && !(clr_v && clr_trk)) |=> $stable(rdy_q));

endmodule

// File: rtl/rr_wait_slot.sv
module rr_wait_slot #(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned TAG_W   = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  regready_pkg::slot_op_e   op,
   input  logic [NUM_SRC*TAG_W-1:0] ld_tag,
   input  logic [NUM_SRC-1:0]       ld_rdy,
   input  logic                     wake_v,
   input  logic [TAG_W-1:0]         wake_tag,
   output logic                     valid,
   output logic [NUM_SRC-1:0]       src_rdy,
   output logic                     eligible
);

   import regready_pkg::*;

   logic                     valid_q;
   logic [NUM_SRC-1:0]       rdy_q;
   logic [NUM_SRC*TAG_W-1:0] tag_q;
   logic [NUM_SRC-1:0]       wake_hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cam
      assign wake_hit[s] = valid_q && !rdy_q[s] && wake_v &&
                           (tag_q[s*TAG_W +: TAG_W] == wake_tag);

      a_r8_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (op == SLOT_HOLD && valid_q && wake_v &&
          (tag_q[s*TAG_W +: TAG_W] == wake_tag)) |=> rdy_q[s]);

      a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (op == SLOT_HOLD && valid_q && rdy_q[s]) |=> rdy_q[s]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rdy_q   <= '0;
         tag_q   <= '0;
      end else begin
         unique case (op)
            SLOT_LOAD: begin
               valid_q <= 1'b1;
               rdy_q   <= ld_rdy;
               tag_q   <= ld_tag;
            end
            SLOT_DROP: begin
               valid_q <= 1'b0;
               rdy_q   <= '0;
            end
            default: begin
               rdy_q   <= rdy_q | wake_hit;
            end
         endcase
      end
   end

   assign valid    = valid_q;
   assign src_rdy  = rdy_q;
   assign eligible = valid_q && (&rdy_q);

   a_r10_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SLOT_DROP) |=> (!valid_q && (rdy_q == '0)));

   a_r10_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && op != SLOT_LOAD) |=> (!valid_q && (rdy_q == '0)));

endmodule

// File: rtl/regready_scoreboard.sv
module regready_scoreboard #(
   parameter int unsigned NUM_PREGS = 64,
   parameter int unsigned TAG_W     = 7,
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned NUM_SRC   = 2,
   localparam int unsigned SLOT_W   = regready_pkg::idx_bits(NUM_SLOTS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         disp_valid,
   input  logic [SLOT_W-1:0]            disp_slot,
   input  logic                         disp_dst_en,
   input  logic [TAG_W-1:0]             disp_dst_tag,
   input  logic [NUM_SRC*TAG_W-1:0]     disp_src_tag,
   input  logic [NUM_SRC-1:0]           disp_src_pre,
   input  logic                         done_valid,
   input  logic [TAG_W-1:0]             done_tag,
   input  logic [NUM_SLOTS-1:0]         flush_mask,
   output logic [NUM_PREGS-1:0]         reg_ready,
   output logic [NUM_SLOTS-1:0]         slot_valid,
   output logic [NUM_SLOTS*NUM_SRC-1:0] slot_src_ready,
   output logic [NUM_SLOTS-1:0]         slot_eligible
);

   import regready_pkg::*;

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("regready_scoreboard: NUM_SLOTS must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("regready_scoreboard: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0] look_rdy;
   logic [NUM_SRC-1:0] ins_rdy;

   rr_ready_file #(
      .NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC)
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_v    (done_valid),
      .set_tag  (done_tag),
      .clr_v    (disp_valid && disp_dst_en),
      .clr_tag  (disp_dst_tag),
      .look_tag (disp_src_tag),
      .look_rdy (look_rdy),
      .rdy_vec  (reg_ready)
   );

   assign ins_rdy = disp_src_pre | look_rdy;

   for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_slot
      slot_op_e op;

      always_comb begin
         if (disp_valid && (disp_slot == SLOT_W'(e))) op = SLOT_LOAD;
         else if (flush_mask[e])                      op = SLOT_DROP;
         else                                         op = SLOT_HOLD;
      end

      rr_wait_slot #(.NUM_SRC(NUM_SRC), .TAG_W(TAG_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .op       (op),
         .ld_tag   (disp_src_tag),
         .ld_rdy   (ins_rdy),
         .wake_v   (done_valid),
         .wake_tag (done_tag),
         .valid    (slot_valid[e]),
         .src_rdy  (slot_src_ready[e*NUM_SRC +: NUM_SRC]),
         .eligible (slot_eligible[e])
      );
   end

   a_r10_insert_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && (32'(disp_slot) < NUM_SLOTS)) |=> slot_valid[$past(disp_slot)]);

endmodule

// File: tb/regready_scoreboard_test.sv
module regready_scoreboard_test;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;
   localparam int TW = 7;
   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 1'b0;
   logic [2:0]  disp_slot = '0;
   logic        disp_dst_en = 1'b0;
   logic [6:0]  disp_dst_tag = '0;
   logic [13:0] disp_src_tag = '0;
   logic [1:0]  disp_src_pre = '0;
   logic        done_valid = 1'b0;
   logic [6:0]  done_tag = '0;
   logic [7:0]  flush_mask = '0;
   logic [63:0] reg_ready;
   logic [7:0]  slot_valid;
   logic [15:0] slot_src_ready;
   logic [7:0]  slot_eligible;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regready_scoreboard uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_dst_en(disp_dst_en),
      .disp_dst_tag(disp_dst_tag), .disp_src_tag(disp_src_tag), .disp_src_pre(disp_src_pre),
      .done_valid(done_valid), .done_tag(done_tag), .flush_mask(flush_mask),
      .reg_ready(reg_ready), .slot_valid(slot_valid),
      .slot_src_ready(slot_src_ready), .slot_eligible(slot_eligible));

   // Reference model
   logic [63:0] m_sb;
   logic [7:0]  m_v;
   logic [15:0] m_r;
   int          m_t [16];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sb = '1;
         m_v  = '0;
         m_r  = '0;
         for (int i = 0; i < 16; i++) m_t[i] = 0;
      end else begin
         for (int e = 0; e < NS; e++) begin
            for (int s = 0; s < 2; s++)
               if (m_v[e] && !m_r[e*2+s] && done_valid && int'(done_tag) == m_t[e*2+s])
                  m_r[e*2+s] = 1'b1;
            if (flush_mask[e]) begin
               m_v[e] = 1'b0;
               m_r[e*2] = 1'b0;
               m_r[e*2+1] = 1'b0;
            end
            if (disp_valid && int'(disp_slot) == e) begin
               m_v[e] = 1'b1;
               for (int s = 0; s < 2; s++) begin
                  int t;
                  t = int'(disp_src_tag[s*TW +: TW]);
                  m_t[e*2+s] = t;
                  m_r[e*2+s] = disp_src_pre[s] || (t >= NP) || m_sb[t % NP] ||
                               (done_valid && int'(done_tag) == t);
               end
            end
         end
         if (done_valid && int'(done_tag) < NP) m_sb[done_tag[5:0]] = 1'b1;
         if (disp_valid && disp_dst_en && int'(disp_dst_tag) < NP) m_sb[disp_dst_tag[5:0]] = 1'b0;
      end
   end

   task automatic check_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         logic [7:0] elig;
         for (int e = 0; e < NS; e++) elig[e] = m_v[e] && m_r[e*2] && m_r[e*2+1];
         check_eq("R2 R3 R4 R5", "model reg_ready", reg_ready, m_sb);
         check_eq("R10", "model slot_valid", 64'(slot_valid), 64'(m_v));
         check_eq("R6 R7 R8", "model slot_src_ready", 64'(slot_src_ready), 64'(m_r));
         check_eq("R9", "model slot_eligible", 64'(slot_eligible), 64'(elig));
      end
   end

   task automatic idle();
      disp_valid = 1'b0; disp_dst_en = 1'b0; disp_dst_tag = '0;
      disp_src_tag = '0; disp_src_pre = '0; disp_slot = '0;
      done_valid = 1'b0; done_tag = '0; flush_mask = '0;
   endtask

   task automatic disp(input int slot, input bit den, input int dst,
                       input int s0, input bit p0, input int s1, input bit p1);
      disp_valid = 1'b1; disp_slot = 3'(slot);
      disp_dst_en = den; disp_dst_tag = 7'(dst);
      disp_src_tag = {7'(s1), 7'(s0)};
      disp_src_pre = {p1, p0};
   endtask

   task automatic done(input int tag);
      done_valid = 1'b1; done_tag = 7'(tag);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] snap;
      idle();
      repeat (3) tick();
      rst_n = 1'b1;
      // R1: reset state
      check_eq("R1", "reg_ready after reset", reg_ready, '1);
      check_eq("R1", "slot_valid after reset", 64'(slot_valid), 64'h0);
      check_eq("R1", "slot_src_ready after reset", 64'(slot_src_ready), 64'h0);
      check_eq("R1", "slot_eligible after reset", 64'(slot_eligible), 64'h0);
      cmp_on = 1'b1;

      // R2, R7: sources found ready in scoreboard; destination cleared
      disp(0, 1, 10, 3, 0, 4, 0); tick(); idle();
      check_eq("R2", "reg 10 cleared", 64'(reg_ready[10]), 64'h0);
      check_eq("R7", "slot0 eligible", 64'(slot_eligible[0]), 64'h1);

      // R8, R5: one waiting source, one untracked source
      disp(1, 1, 11, 10, 0, 127, 0); tick(); idle();
      check_eq("R5", "slot1 untracked src ready", 64'(slot_src_ready[3:2]), 64'h2);
      check_eq("R9", "slot1 not eligible", 64'(slot_eligible[1]), 64'h0);

      // R6: rename-ready flag on a not-ready register
      disp(2, 1, 12, 10, 1, 11, 0); tick(); idle();
      check_eq("R6", "slot2 src0 ready by rename", 64'(slot_src_ready[5:4]), 64'h1);

      // R3, R8, R9: completion wakes the waiting source
      done(10); tick(); idle();
      check_eq("R3", "reg 10 set", 64'(reg_ready[10]), 64'h1);
      check_eq("R8", "slot1 woken", 64'(slot_src_ready[3:2]), 64'h3);
      check_eq("R9", "slot1 eligible", 64'(slot_eligible[1]), 64'h1);

      // R7 bypass and R8 multi-slot wake in one cycle
      disp(3, 1, 20, 11, 0, 11, 0); done(11); tick(); idle();
      check_eq("R7", "slot3 same-cycle bypass", 64'(slot_src_ready[7:6]), 64'h3);
      check_eq("R8", "slot2 woken", 64'(slot_src_ready[5:4]), 64'h3);
      check_eq("R2", "reg 20 cleared", 64'(reg_ready[20]), 64'h0);

      // R4: dispatch and completion on the same register
      disp(4, 1, 30, 20, 0, 20, 0); done(30); tick(); idle();
      check_eq("R4", "reg 30 dispatch wins", 64'(reg_ready[30]), 64'h0);
      check_eq("R8", "slot4 waiting", 64'(slot_src_ready[9:8]), 64'h0);

      // R10: flush while the awaited value completes
      flush_mask = 8'h10; done(20); tick(); idle();
      check_eq("R10", "slot4 flushed", 64'(slot_valid[4]), 64'h0);
      check_eq("R10", "slot4 srcs cleared", 64'(slot_src_ready[9:8]), 64'h0);
      done(20); tick(); idle();
      check_eq("R10", "slot4 not revived", 64'({slot_valid[4], slot_src_ready[9:8]}), 64'h0);

      // R5: untracked destination and completion
      snap = reg_ready;
      disp(6, 1, 100, 90, 0, 5, 0); done(120); tick(); idle();
      check_eq("R5", "reg_ready unchanged", reg_ready, snap);
      check_eq("R5", "slot6 srcs ready", 64'(slot_src_ready[13:12]), 64'h3);

      // R10: insert beats flush on the same slot
      disp(5, 1, 40, 30, 0, 30, 0); flush_mask = 8'h20; tick(); idle();
      check_eq("R10", "slot5 insert wins", 64'(slot_valid[5]), 64'h1);
      check_eq("R8", "slot5 waits on 30", 64'(slot_src_ready[11:10]), 64'h0);
      done(30); tick(); idle();
      check_eq("R8", "slot5 woken", 64'(slot_src_ready[11:10]), 64'h3);

      // R7: own destination clear does not hide the source lookup
      disp(7, 1, 33, 33, 0, 1, 0); tick(); idle();
      check_eq("R7", "slot7 reads pre-dispatch state", 64'(slot_src_ready[15:14]), 64'h3);
      check_eq("R2", "reg 33 cleared", 64'(reg_ready[33]), 64'h0);

      // Random traffic, compared against the model every cycle
      for (int n = 0; n < 3000; n++) begin
         int t [4];
         for (int k = 0; k < 4; k++)
            t[k] = ($urandom_range(0, 9) < 7) ? int'($urandom_range(0, 15))
                                              : int'($urandom_range(0, 127));
         idle();
         if ($urandom_range(0, 2) != 0)
            disp(int'($urandom_range(0, 7)), $urandom_range(0, 3) != 0, t[0],
                 t[1], $urandom_range(0, 5) == 0, t[2], $urandom_range(0, 5) == 0);
         if ($urandom_range(0, 1) != 0) done(t[3]);
         if ($urandom_range(0, 5) == 0) flush_mask = 8'($urandom_range(0, 255));
         tick();
      end
      idle();
      tick();
      finish_run();
   end

endmodule